// File: doc/BRIEF.md
# MDIO Station Management Master

This block is a register-driven management master. It issues MDIO read and write frames, using the 32-bit-preamble frame layout, toward external PHY devices. A host reaches it through four word-indexed registers on a simple synchronous bus. The registers hold a control word, the captured read result, the write data and the target address. The block also reports a busy flag and a read-valid flag. On the line side it produces the management clock MDC by dividing the system clock. It drives the bidirectional data pin as a separate output and output-enable pair, and it takes the pin's value back on one input.

There are three ways to start a frame. A one-shot read runs a single read frame. A scan read runs read frames back to back for as long as its control bit stays set, so the host can poll a status register of a PHY. Storing a word into the write-data register starts a write frame that uses the address already held in the target register. A request that arrives while a frame is running waits until that frame ends. When more than one request is waiting, a stored write goes first, then a one-shot read, then a scan read.

The frame sequencer is a five-state machine. ST_IDLE goes to ST_PRE on a drive tick while a request is pending, which is the launch. ST_PRE goes to ST_HDR after the preamble bits. ST_HDR goes to ST_TA after 14 bits: start, opcode, PHY address and register address. ST_TA goes to ST_DATA after the 2 turnaround bits. ST_DATA returns to ST_IDLE after 16 data bits, which is the completion. The machine moves only on drive ticks. A drive tick falls one system clock after each rising edge of MDC.

Top module: `mdio_master`

## Requirements
- R1: Writing 1 to bit 0 of the control register (index 0) produces exactly one read frame. At its end, the 16 sampled bits appear zero-extended in the read-data register (index 1). Bit 0 reads back as 1 while that read is still waiting to be launched.
- R2: While bit 1 of the control register is 1, read frames follow one another without end, and each completed frame refreshes the read-data register. After the bit is cleared, the frame in progress finishes and no further frame starts.
- R3: The target register (index 3) keeps the register address in bits 4:0 and the PHY address in bits 12:8. Every other bit reads as zero.
- R4: Any write to the write-data register (index 2) starts a write frame. The frame carries bits 15:0 of the written word and the PHY and register addresses stored in the target register.
- R5: Each frame sends, in order: PRE_BITS ones, start bits 0 then 1, an opcode (1,0 for a read; 0,1 for a write), the 5-bit PHY address MSB first, and the 5-bit register address MSB first.
- R6: Writes to the read-data register change nothing. The write-data register and bits 31:16 of the read-data register always read as zero.
- R7: After reset, every register reads zero, busy and read-valid are low, and the data pin is released.
- R8: In a write frame the master drives turnaround bits 1,0 and then 16 data bits MSB first. In a read frame the master releases the pin from the first turnaround bit to the end of the frame and samples the data bits on rising MDC edges. Between frames the pin is released.
- R9: Busy is high from the launch of a frame through its last bit. A request made while busy is held and then served after the current frame, with a write ahead of a one-shot read, and a one-shot read ahead of a scan read.
- R10: Read-valid drops when a read frame is launched and rises when that read frame completes.
- R11: MDC has a period of 2*MDC_HALF system clocks. The master changes its data output one system clock after each rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index: 0 control, 1 read data, 2 write data, 3 target |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| busy | output | 1 | A frame is in progress |
| rd_valid | output | 1 | Read-data register holds the result of the latest read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with MDC_HALF = 3. This odd divider gives a six-clock MDC period, so the divider's wrap point does not fall at a power-of-two count, and a full frame is short enough for back-to-back scan frames and queued requests to fit in one run. PRE_BITS keeps its default of 32, so the captured frames can be checked bit for bit against the full preamble length. A PHY responder in the bench rebuilds each 64-bit frame from the line and drives read data after rising MDC edges. This exposes the exact turnaround, bus release and sampling instants.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int ADR_W     = 5;
    localparam int TX_W      = HDR_BITS + TA_BITS + DATA_BITS;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    localparam logic [1:0] RG_CTRL   = 2'd0;
    localparam logic [1:0] RG_RDATA  = 2'd1;
    localparam logic [1:0] RG_WDATA  = 2'd2;
    localparam logic [1:0] RG_TARGET = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise,
    output logic tick
);
    localparam int CW = (MDC_HALF < 2) ? 1 : $clog2(MDC_HALF);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(MDC_HALF - 1));
    assign rise = wrap & ~mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            mdc  <= 1'b0;
            tick <= 1'b0;
        end else begin
            tick <= rise;
            if (wrap) begin
                cnt <= '0;
                mdc <= ~mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mdc)); // R11
    AST_TICK_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> tick); // R11
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 tick,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [ADR_W-1:0]     phy_adr,
    input  logic [ADR_W-1:0]     reg_adr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 mdio_i,
    output logic                 launch,
    output logic                 done,
    output logic                 done_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe
);
    localparam int CNT_W = (PRE_BITS < 16) ? 4 : $clog2(PRE_BITS);

    mdio_state_e          state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [TX_W-1:0]      tx_sr;
    logic [DATA_BITS-1:0] rx_sr;
    logic                 op_wr;
    logic                 last_bit;

    // bit count reaches the length of the current field
    always_comb begin
        unique case (state)
            ST_PRE:  last_bit = (cnt == CNT_W'(PRE_BITS - 1));
            ST_HDR:  last_bit = (cnt == CNT_W'(HDR_BITS - 1));
            ST_TA:   last_bit = (cnt == CNT_W'(TA_BITS - 1));
            ST_DATA: last_bit = (cnt == CNT_W'(DATA_BITS - 1));
            default: last_bit = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (tick && req)      nxt = ST_PRE;
            ST_PRE:  if (tick && last_bit) nxt = ST_HDR;
            ST_HDR:  if (tick && last_bit) nxt = ST_TA;
            ST_TA:   if (tick && last_bit) nxt = ST_DATA;
            ST_DATA: if (tick && last_bit) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
            op_wr <= 1'b0;
        end else begin
            if (tick) begin
                if (nxt != state) cnt <= '0;
                else if (state != ST_IDLE) cnt <= cnt + 1'b1;
            end
            if (launch) begin
                op_wr <= req_wr;
                tx_sr <= {SOF_BITS, (req_wr ? OP_WRITE : OP_READ), phy_adr, reg_adr,
                          (req_wr ? TA_WRITE : 2'b00), (req_wr ? wdata : '0)};
            end else if (tick && (state == ST_HDR || state == ST_TA || state == ST_DATA)) begin
                tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            end
            if (rise && state == ST_DATA && !op_wr) begin
                rx_sr <= {rx_sr[DATA_BITS-2:0], mdio_i};
            end
        end
    end

    always_comb begin
        launch  = (state == ST_IDLE) && tick && req;
        done    = (state == ST_DATA) && tick && last_bit;
        done_rd = done && !op_wr;
        rx_data = rx_sr;
        busy    = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin mdio_o = 1'b0;         mdio_oe = 1'b0;  end
            ST_PRE:  begin mdio_o = 1'b1;         mdio_oe = 1'b1;  end
            ST_HDR:  begin mdio_o = tx_sr[TX_W-1]; mdio_oe = 1'b1; end
            ST_TA:   begin mdio_o = tx_sr[TX_W-1]; mdio_oe = op_wr; end
            ST_DATA: begin mdio_o = tx_sr[TX_W-1]; mdio_oe = op_wr; end
            default: begin mdio_o = 1'b0;         mdio_oe = 1'b0;  end
        endcase
    end

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TA || state == ST_DATA) && !op_wr) |-> !mdio_oe); // R8
    AST_PRE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> (mdio_oe && mdio_o)); // R5
    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state)); // R11
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic        rd_valid,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                 rise, tick;
    logic                 launch, done, done_rd;
    logic [DATA_BITS-1:0] rx_data;
    logic                 scan_q, rd_pend, wr_pend;
    logic [ADR_W-1:0]     tgt_phy, tgt_reg;
    logic [DATA_BITS-1:0] wdat_q, rdat_q;
    logic                 req;
    logic                 unused_hi;

    assign unused_hi = ^bus_wdata[31:16];
    // priority: stored write, then one-shot read, then scan
    assign req = wr_pend | rd_pend | scan_q;

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise(rise), .tick(tick)
    );

    mdio_frame_fsm #(.PRE_BITS(PRE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .tick(tick),
        .req(req), .req_wr(wr_pend), .phy_adr(tgt_phy), .reg_adr(tgt_reg),
        .wdata(wdat_q), .mdio_i(mdio_i), .launch(launch), .done(done),
        .done_rd(done_rd), .rx_data(rx_data), .busy(busy),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q   <= 1'b0;
            rd_pend  <= 1'b0;
            wr_pend  <= 1'b0;
            tgt_phy  <= '0;
            tgt_reg  <= '0;
            wdat_q   <= '0;
            rdat_q   <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (launch) begin
                if (wr_pend) begin
                    wr_pend <= 1'b0;
                end else begin
                    rd_pend  <= 1'b0;
                    rd_valid <= 1'b0;
                end
            end
            if (done_rd) begin
                rdat_q   <= rx_data;
                rd_valid <= 1'b1;
            end
            if (bus_we) begin
                unique case (bus_addr)
                    RG_CTRL: begin
                        scan_q <= bus_wdata[1];
                        if (bus_wdata[0]) rd_pend <= 1'b1;
                    end
                    RG_WDATA: begin
                        wdat_q  <= bus_wdata[DATA_BITS-1:0];
                        wr_pend <= 1'b1;
                    end
                    RG_TARGET: begin
                        tgt_reg <= bus_wdata[4:0];
                        tgt_phy <= bus_wdata[12:8];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            RG_CTRL:   bus_rdata = {30'd0, scan_q, rd_pend};
            RG_RDATA:  bus_rdata = {16'd0, rdat_q};
            RG_TARGET: bus_rdata = {19'd0, tgt_phy, 3'd0, tgt_reg};
            default:   bus_rdata = 32'd0;
        endcase
    end

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done_rd |=> rd_valid); // R10
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_rd |=> $stable(rdat_q)); // R2
    AST_NO_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req && !bus_we) |=> !busy); // R9
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R8
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        busy, rd_valid, mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_oe = 1'b0;
    logic        phy_bit = 1'b1;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

    mdio_master #(.MDC_HALF(HALF), .PRE_BITS(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rd_valid(rd_valid), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY responder and frame capture
    logic [63:0] cur = '0;
    logic [63:0] flog [0:15];
    int          idx = 0;
    bit          in_frame = 0;
    int          frame_count = 0;
    logic [15:0] phy_word = 16'h0;
    bit          scan_inc = 0;
    int          oe_viol = 0;

    always @(posedge mdc) begin
        int nx;
        if (!in_frame && mdio_oe) begin
            in_frame = 1;
            idx = 0;
        end
        if (in_frame) begin
            cur[63-idx] = mdio_i;
            if (idx >= 46 && cur[29:28] == 2'b10 && mdio_oe) oe_viol++;
            if (idx == 63) begin
                flog[frame_count % 16] = cur;
                frame_count++;
                in_frame = 0;
                phy_oe = 0;
                if (scan_inc) phy_word++;
            end else begin
                nx = idx + 1;
                if (cur[29:28] == 2'b10 && nx >= 47) begin
                    phy_oe = 1;
                    phy_bit = (nx == 47) ? 1'b0 : phy_word[63-nx];
                end
                idx = nx;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_busy();
        while (!busy) @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        int target = frame_count + n;
        while (frame_count < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), d);
            check(d == 32'd0, "R7 register reset", d, 0);
        end
        check(!busy && !rd_valid && !mdio_oe, "R7 status reset",
              {busy, rd_valid, mdio_oe}, 0);
    endtask

    task automatic t_target();
        logic [31:0] d;
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_read(2'd3, d);
        check(d == 32'h0000_1F1F, "R3 target mask", d, 32'h1F1F);
        bus_write(2'd3, 32'h0000_0A11);
        bus_read(2'd3, d);
        check(d == 32'h0000_0A11, "R3 target fields", d, 32'h0A11);
    endtask

    task automatic t_write();
        logic [31:0] d;
        bus_write(2'd2, 32'hDEAD_BEEF);
        repeat (4 * HALF + 2) @(negedge clk);
        check(busy == 1'b1, "R9 busy during write", busy, 1);
        bus_read(2'd2, d);
        check(d == 32'd0, "R6 write data reads zero", d, 0);
        wait_frames(1);
        check(flog[(frame_count-1) % 16] == mk(2'b01, 5'h0A, 5'h11, 16'hBEEF),
              "R4 R5 R8 write frame", flog[(frame_count-1) % 16],
              mk(2'b01, 5'h0A, 5'h11, 16'hBEEF));
        check(!mdio_oe && !busy, "R8 pin released after frame", {busy, mdio_oe}, 0);
    endtask

    task automatic t_read();
        logic [31:0] d;
        int fc;
        bus_write(2'd3, 32'h0000_0102);
        phy_word = 16'hA5C3;
        oe_viol = 0;
        bus_write(2'd0, 32'h1);
        bus_read(2'd0, d);
        check(d == 32'h1, "R1 one-shot read pending", d, 1);
        wait_busy();
        @(negedge clk);
        check(rd_valid == 1'b0, "R10 valid cleared at launch", rd_valid, 0);
        wait_frames(1);
        bus_read(2'd1, d);
        check(d == 32'h0000_A5C3, "R1 read result", d, 32'hA5C3);
        check(rd_valid == 1'b1, "R10 valid after read", rd_valid, 1);
        check(flog[(frame_count-1) % 16] == mk(2'b10, 5'h01, 5'h02, 16'hA5C3),
              "R5 read frame", flog[(frame_count-1) % 16],
              mk(2'b10, 5'h01, 5'h02, 16'hA5C3));
        check(oe_viol == 0, "R8 release during read", oe_viol, 0);
        fc = frame_count;
        repeat (300) @(negedge clk);
        check(frame_count == fc && !busy, "R1 exactly one frame", frame_count, fc);
        bus_write(2'd1, 32'hFFFF_1111);
        bus_read(2'd1, d);
        check(d == 32'h0000_A5C3, "R6 read data ignores writes", d, 32'hA5C3);
    endtask

    task automatic t_queue();
        logic [31:0] d;
        phy_word = 16'h0F0F;
        bus_write(2'd0, 32'h1);
        wait_busy();
        bus_write(2'd2, 32'h0000_1234);
        check(busy == 1'b1, "R9 write held while busy", busy, 1);
        wait_frames(2);
        check(flog[(frame_count-2) % 16] == mk(2'b10, 5'h01, 5'h02, 16'h0F0F),
              "R9 first queued frame", flog[(frame_count-2) % 16],
              mk(2'b10, 5'h01, 5'h02, 16'h0F0F));
        check(flog[(frame_count-1) % 16] == mk(2'b01, 5'h01, 5'h02, 16'h1234),
              "R9 held write frame", flog[(frame_count-1) % 16],
              mk(2'b01, 5'h01, 5'h02, 16'h1234));
        bus_read(2'd1, d);
        check(d == 32'h0000_0F0F, "R1 queued read result", d, 32'h0F0F);
    endtask

    task automatic t_scan();
        logic [31:0] d;
        int fc;
        phy_word = 16'h1000;
        scan_inc = 1;
        bus_write(2'd0, 32'h2);
        wait_frames(1);
        bus_read(2'd1, d);
        check(d == 32'h0000_1000, "R2 first scan result", d, 32'h1000);
        wait_frames(1);
        bus_read(2'd1, d);
        check(d == 32'h0000_1001, "R2 second scan result", d, 32'h1001);
        bus_write(2'd0, 32'h0);
        while (busy) @(negedge clk);
        fc = frame_count;
        repeat (600) @(negedge clk);
        check(frame_count == fc && !busy, "R2 scan stops when cleared", frame_count, fc);
        scan_inc = 0;
    endtask

    task automatic t_mdc();
        time t0, t1;
        @(posedge mdc);
        t0 = $time;
        @(posedge mdc);
        t1 = $time;
        check((t1 - t0) == 2 * HALF * 10, "R11 MDC period", t1 - t0, 2 * HALF * 10);
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_target();
        t_write();
        t_read();
        t_queue();
        t_scan();
        t_mdc();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule